// File: doc/BRIEF.md
# Synchronous DRAM Command Front End

This block sits behind the pins of a four-bank, sixteen-bit synchronous DRAM and turns the sampled control, address, bank and byte-mask pins into decoded command strobes. Every input is sampled on the rising clock edge. The clock-enable value captured at one edge decides whether the next edge is valid. An invalid edge issues no internal clock, so every piece of state holds. While chip select is high, new commands are ignored, but a burst that is already running keeps advancing.

The block keeps an open flag and an open-row register for each bank. It counts out fixed-length bursts and closes a bank after its last beat when auto-precharge was requested. It enters and leaves power-down from clock enable. It also produces two byte-mask outputs. The write byte enable follows the mask pins with no latency. The read output-disable follows them two valid edges later.

The controller has three states:
- `FS_IDLE`: no burst is in progress.
- `FS_BURST`: a burst is counting its beats.
- `FS_PDOWN`: the device is powered down.

The transitions between them are:
- IDLE→BURST: a read or write to an open bank is accepted. This also applies from BURST, where the new command restarts the burst.
- BURST→IDLE: the last beat of the burst.
- IDLE→PDOWN: clock enable is sampled low while the next state is IDLE.
- PDOWN→IDLE: clock enable is sampled high.

Top module: `sdram_cmd_front`

## Requirements
- R1: When clock enable is sampled low at an edge, the next edge is invalid. On an invalid edge the block produces no strobe, decodes no command, and freezes the burst count and the read mask pipeline.
- R2: While chip select is high at a valid edge, no command is decoded or reported, and a burst in progress still advances one beat.
- R3: With chip select low, the pin code {ras_n,cas_n,we_n} decodes as follows: 011 is activate, 101 is read, 100 is write, 010 is precharge and 111 is no-operation. Any other code pulses bad_cmd_o for one cycle.
- R4: The bank select value {ba[1],ba[0]} 00, 01, 10 or 11 selects bank 0, 1, 2 or 3. An activate opens that bank, stores addr[11:0] as its row, and reports the bank on bank_o and the row on row_o.
- R5: A read or write to an open bank pulses rd_o or wr_o. In the same cycle it reports col_o = addr[8:0], row_o = the stored row of that bank, and auto_pre_o = addr[10].
- R6: A precharge pulses pre_o. With addr[10] = 1 it closes all banks and pulses pre_all_o. With addr[10] = 0 it closes only the selected bank.
- R7: A read or write to a closed bank pulses closed_err_o. It gives no rd_o or wr_o strobe and starts no burst.
- R8: A burst covers BURST_LEN valid edges, counting the command edge. If auto-precharge was requested, the bank closes at the last beat.
- R9: wr_be_o equals the inverted masks sampled at the same edge ({upper,lower} = bit 1, bit 0) on a write command edge and on each later beat of a write burst. Otherwise it is 0.
- R10: rd_mask_o shows the masks sampled at a valid edge after the following valid edge, which means two valid edges before the data they govern. It resets to 11, meaning both drivers are off.
- R11: Clock enable sampled low while the next state is idle raises pdown_o after that edge. Clock enable low during a burst does not enter power-down. Clock enable sampled high in power-down clears pdown_o after that edge.
- R12: After reset all strobes are 0, pdown_o is 0 and every bank is closed. Command strobes last one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cke_i | input | 1 | Clock enable for the next edge |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe pin |
| cas_n_i | input | 1 | Column strobe pin |
| we_n_i | input | 1 | Write enable pin |
| addr_i | input | 12 | Address pins; bit 10 is the precharge-all / auto-precharge flag |
| ba_i | input | 2 | Bank select |
| bytemask_i | input | 2 | Byte masks, bit 1 upper, bit 0 lower |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| pre_all_o | output | 1 | Precharge covers all banks |
| auto_pre_o | output | 1 | Read/write requests auto-precharge |
| bad_cmd_o | output | 1 | Unsupported command pulse |
| closed_err_o | output | 1 | Access to a closed bank |
| bank_o | output | 2 | Bank of last command |
| row_o | output | 12 | Row of last activate or access |
| col_o | output | 9 | Column of last access |
| wr_be_o | output | 2 | Write byte enables |
| rd_mask_o | output | 2 | Read output-disable per byte |
| pdown_o | output | 1 | Power-down active |

## Verification
Some events have to line up at the same edge, and those are the hardest to reach from the pins. One example is a burst ending with auto-precharge in the same valid edge that clock enable drops. Another is a burst frozen by clock enable and then resumed. A third is a command hidden by chip select during a burst. Directed sequences place clock enable, chip select and bank state at those exact edges. A seeded random phase then mixes all five codes, unsupported codes, masks and occasional clock-enable drops. The resulting state, including bank state and power-down, is checked against a bench reference model edge by edge.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_BAD
    } fe_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_BURST,
        FS_PDOWN
    } fe_state_e;

    localparam logic [2:0] PIN_ACT = 3'b011;
    localparam logic [2:0] PIN_RD  = 3'b101;
    localparam logic [2:0] PIN_WR  = 3'b100;
    localparam logic [2:0] PIN_PRE = 3'b010;
    localparam logic [2:0] PIN_NOP = 3'b111;
endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
    import sdram_fe_pkg::*;
(
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    output fe_cmd_e cmd
);
    logic [2:0] code;
    assign code = {ras_n, cas_n, we_n};

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case (code)
                PIN_ACT: cmd = CMD_ACT;
                PIN_RD:  cmd = CMD_RD;
                PIN_WR:  cmd = CMD_WR;
                PIN_PRE: cmd = CMD_PRE;
                PIN_NOP: cmd = CMD_NOP;
                default: cmd = CMD_BAD;
            endcase
        end
    end
endmodule

// File: rtl/fe_bank_slot.sv
module fe_bank_slot #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_d,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (open_set) begin
            open_o <= 1'b1;
            row_o  <= row_d;
        end else if (close) begin
            open_o <= 1'b0;
        end
    end

    // R4: an activate leaves the bank open holding the given row
    a_r4_row_load: assert property (@(posedge clk) disable iff (!rst_n)
        open_set |=> (open_o && row_o == $past(row_d)));
    // R6: a close with no activate leaves the bank shut
    a_r6_close_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !open_set) |=> !open_o);
endmodule

// File: rtl/fe_mask_pipe.sv
module fe_mask_pipe #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  stg[0] <= '1;
                else if (en) stg[0] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  stg[g] <= '1;
                else if (en) stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

    // R10: an invalid edge freezes the read mask output
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_fe_pkg::*;
#(
    parameter int ROW_W       = 12,
    parameter int COL_W       = 9,
    parameter int BANK_W      = 2,
    parameter int BURST_LEN   = 4,
    parameter int RD_MASK_LAT = 2,
    parameter int AP_BIT      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [ROW_W-1:0]  addr_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [1:0]        bytemask_i,
    output logic              act_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              pre_o,
    output logic              pre_all_o,
    output logic              auto_pre_o,
    output logic              bad_cmd_o,
    output logic              closed_err_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [1:0]        wr_be_o,
    output logic [1:0]        rd_mask_o,
    output logic              pdown_o
);
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int CNT_W     = $clog2(BURST_LEN) + 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    fe_state_e         state_q, state_d;
    fe_cmd_e           cmd;
    logic              cke_q;
    logic              valid;
    logic [CNT_W-1:0]  cnt_q;
    logic              ap_pend_q;
    logic [BANK_W-1:0] ap_bank_q;
    logic              burst_wr_q;
    logic              tgt_open;
    logic              is_access;
    logic              start;
    logic              beat;
    logic              last;
    logic              burst_close;
    logic [NUM_BANKS-1:0] open_v;
    logic [ROW_W-1:0]  row_v [NUM_BANKS];

    fe_cmd_decode u_dec (
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .cmd   (cmd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke_i;
    end

    assign valid       = cke_q;
    assign tgt_open    = open_v[ba_i];
    assign is_access   = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign start       = valid && is_access && tgt_open;
    assign beat        = valid && !start && (state_q == FS_BURST);
    assign last        = beat && (cnt_q == CNT_LAST);
    assign burst_close = last && ap_pend_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        logic set_g;
        logic close_g;
        assign sel     = (ba_i == BANK_W'(g));
        assign set_g   = valid && (cmd == CMD_ACT) && sel;
        assign close_g = (valid && (cmd == CMD_PRE) && (addr_i[AP_BIT] || sel))
                       || (burst_close && (ap_bank_q == BANK_W'(g)));
        fe_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_set (set_g),
            .close    (close_g),
            .row_d    (addr_i),
            .open_o   (open_v[g]),
            .row_o    (row_v[g])
        );
    end

    fe_mask_pipe #(.W(2), .DEPTH(RD_MASK_LAT)) u_rdmask (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (valid),
        .din   (bytemask_i),
        .dout  (rd_mask_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (start) state_d = FS_BURST;
            FS_BURST: begin
                if (start)     state_d = FS_BURST;
                else if (last) state_d = FS_IDLE;
            end
            FS_PDOWN: state_d = FS_PDOWN;
            default:  state_d = FS_IDLE;
        endcase
        if (state_d == FS_PDOWN && cke_i)
            state_d = FS_IDLE;
        else if (state_d == FS_IDLE && !cke_i)
            state_d = FS_PDOWN;
    end

    assign pdown_o = (state_q == FS_PDOWN);

    // Burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            ap_pend_q  <= 1'b0;
            ap_bank_q  <= '0;
            burst_wr_q <= 1'b0;
        end else if (start) begin
            cnt_q      <= CNT_LOAD;
            ap_pend_q  <= addr_i[AP_BIT];
            ap_bank_q  <= ba_i;
            burst_wr_q <= (cmd == CMD_WR);
        end else if (beat && !last) begin
            cnt_q <= cnt_q - CNT_LAST;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_o        <= 1'b0;
            rd_o         <= 1'b0;
            wr_o         <= 1'b0;
            pre_o        <= 1'b0;
            pre_all_o    <= 1'b0;
            auto_pre_o   <= 1'b0;
            bad_cmd_o    <= 1'b0;
            closed_err_o <= 1'b0;
            bank_o       <= '0;
            row_o        <= '0;
            col_o        <= '0;
            wr_be_o      <= '0;
        end else begin
            act_o        <= valid && (cmd == CMD_ACT);
            rd_o         <= start && (cmd == CMD_RD);
            wr_o         <= start && (cmd == CMD_WR);
            pre_o        <= valid && (cmd == CMD_PRE);
            pre_all_o    <= valid && (cmd == CMD_PRE) && addr_i[AP_BIT];
            auto_pre_o   <= start && addr_i[AP_BIT];
            bad_cmd_o    <= valid && (cmd == CMD_BAD);
            closed_err_o <= valid && is_access && !tgt_open;
            if (valid && (cmd == CMD_ACT || cmd == CMD_PRE || start))
                bank_o <= ba_i;
            if (valid && cmd == CMD_ACT)
                row_o <= addr_i;
            else if (start)
                row_o <= row_v[ba_i];
            if (start)
                col_o <= addr_i[COL_W-1:0];
            if ((start && cmd == CMD_WR) || (beat && burst_wr_q))
                wr_be_o <= ~bytemask_i;
            else
                wr_be_o <= '0;
        end
    end

    // R12: at most one command strobe per cycle
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_o, rd_o, wr_o, pre_o, bad_cmd_o, closed_err_o}));
    // R1: an invalid edge yields no strobe
    a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |=> !(act_o || rd_o || wr_o || pre_o || bad_cmd_o || closed_err_o));
    // R9: no write byte enable alongside a read strobe
    a_r9_no_be_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (wr_be_o == 2'b00));
    // R11: a settled power-down shows no strobes
    a_r11_quiet_pdown: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown_o && $past(pdown_o)) |-> !(act_o || rd_o || wr_o || pre_o));
    // R6: precharge-all only with a precharge strobe
    a_r6_all_with_pre: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |-> pre_o);
    // R5: auto-precharge flag only with an access strobe
    a_r5_ap_with_access: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> (rd_o || wr_o));
endmodule

// File: tb/sim_sdram_cmd_front.sv
module sim_sdram_cmd_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0]  ba, bm;
    logic        act_o, rd_o, wr_o, pre_o, pre_all_o, auto_pre_o, bad_cmd_o, closed_err_o;
    logic [1:0]  bank_o;
    logic [11:0] row_o;
    logic [8:0]  col_o;
    logic [1:0]  wr_be_o, rd_mask_o;
    logic        pdown_o;

    localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                           K_PRE = 3'b010, K_NOP = 3'b111, K_BAD = 3'b000;
    localparam int BL = 4;

    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .addr_i(addr), .ba_i(ba), .bytemask_i(bm),
        .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .pre_all_o(pre_all_o),
        .auto_pre_o(auto_pre_o), .bad_cmd_o(bad_cmd_o), .closed_err_o(closed_err_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .wr_be_o(wr_be_o),
        .rd_mask_o(rd_mask_o), .pdown_o(pdown_o)
    );

    // reference model state
    bit        m_open [4];
    bit [11:0] m_row [4];
    int        m_st;             // 0 idle, 1 burst, 2 power-down
    int        m_cnt;
    bit        m_ap, m_bw, m_ckeq;
    bit [1:0]  m_apb, m_p1, m_p2;
    bit        e_act, e_rd, e_wr, e_pre, e_all, e_ap, e_bad, e_err;
    bit [1:0]  e_bank, e_wrbe;
    bit [11:0] e_row;
    bit [8:0]  e_col;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = '0; end
        m_st = 0; m_cnt = 0; m_ap = 0; m_bw = 0; m_ckeq = 1; m_apb = 0;
        m_p1 = 2'b11; m_p2 = 2'b11;
        {e_act, e_rd, e_wr, e_pre, e_all, e_ap, e_bad, e_err} = '0;
        e_bank = 0; e_wrbe = 0; e_row = 0; e_col = 0;
    endtask

    // one edge of the reference model, from the pins seen at that edge
    task automatic model_step();
        bit [2:0] k;
        bit v, st, isacc;
        v = m_ckeq;
        k = {ras_n, cas_n, we_n};
        {e_act, e_rd, e_wr, e_pre, e_all, e_ap, e_bad, e_err} = '0;
        e_wrbe = 0;
        st = 0;
        if (v && !cs_n) begin
            isacc = (k == K_RD) || (k == K_WR);
            if (k == K_ACT) begin
                e_act = 1; e_bank = ba; e_row = addr;
            end else if (isacc && m_open[ba]) begin
                st = 1; e_rd = (k == K_RD); e_wr = (k == K_WR);
                e_bank = ba; e_row = m_row[ba]; e_col = addr[8:0]; e_ap = addr[10];
                if (k == K_WR) e_wrbe = ~bm;
            end else if (isacc) begin
                e_err = 1;
            end else if (k == K_PRE) begin
                e_pre = 1; e_all = addr[10]; e_bank = ba;
            end else if (k != K_NOP) begin
                e_bad = 1;
            end
        end
        if (st) begin
            m_st = 1; m_cnt = BL - 1; m_ap = addr[10]; m_apb = ba; m_bw = (k == K_WR);
        end else if (v && m_st == 1) begin
            if (m_bw) e_wrbe = ~bm;
            if (m_cnt == 1) begin
                m_st = 0;
                if (m_ap) m_open[m_apb] = 0;
            end else m_cnt--;
        end
        if (e_act) begin m_open[ba] = 1; m_row[ba] = addr; end
        if (e_pre) begin
            for (int i = 0; i < 4; i++) if (addr[10] || ba == 2'(i)) m_open[i] = 0;
        end
        if (v) begin m_p2 = m_p1; m_p1 = bm; end
        if (m_st == 2 && cke) m_st = 0;
        else if (m_st == 0 && !cke) m_st = 2;
        m_ckeq = cke;
    endtask

    task automatic compare();
        check({act_o, rd_o, wr_o, pre_o} == {e_act, e_rd, e_wr, e_pre}, "R3 strobes",
              {act_o, rd_o, wr_o, pre_o}, {e_act, e_rd, e_wr, e_pre});
        check(bad_cmd_o == e_bad, "R3 bad_cmd", bad_cmd_o, e_bad);
        check(bank_o == e_bank, "R4 bank", bank_o, e_bank);
        check(row_o == e_row, "R4/R5 row", row_o, e_row);
        check(col_o == e_col && auto_pre_o == e_ap, "R5 col/ap",
              {auto_pre_o, col_o}, {e_ap, e_col});
        check(pre_all_o == e_all, "R6 pre_all", pre_all_o, e_all);
        check(closed_err_o == e_err, "R7 closed_err", closed_err_o, e_err);
        check(wr_be_o == e_wrbe, "R9 wr_be", wr_be_o, e_wrbe);
        check(rd_mask_o == m_p2, "R10 rd_mask", rd_mask_o, m_p2);
        check(pdown_o == (m_st == 2), "R11 pdown", pdown_o, m_st == 2);
    endtask

    task automatic step(input bit c, input bit cs, input bit [2:0] k,
                        input bit [11:0] a, input bit [1:0] b, input bit [1:0] m);
        cke = c; cs_n = cs; {ras_n, cas_n, we_n} = k; addr = a; ba = b; bm = m;
        @(posedge clk);
        model_step();
        #2;
        compare();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5d3a_11c7));
        rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = K_NOP;
        addr = 0; ba = 0; bm = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        check({act_o, rd_o, wr_o, pre_o, bad_cmd_o, closed_err_o, pdown_o} == 0,
              "R12 reset strobes", act_o, 0);
        check(rd_mask_o == 2'b11, "R12 reset rd_mask", rd_mask_o, 3);

        // R7: read of a closed bank after reset
        step(1, 0, K_RD, 12'h005, 2'd1, 2'b00);
        check(closed_err_o == 1 && rd_o == 0, "R7 closed read", closed_err_o, 1);

        // R4/R5: activate bank 2, read with auto-precharge
        step(1, 0, K_ACT, 12'hABC, 2'd2, 2'b00);
        step(1, 0, K_RD, 12'h412, 2'd2, 2'b01);
        check(row_o == 12'hABC && col_o == 9'h012 && auto_pre_o, "R5 read fields", row_o, 12'hABC);
        // R2: chip-select-high activate hidden during burst
        step(1, 1, K_ACT, 12'h111, 2'd3, 2'b10);
        // R1: clock enable low freezes burst
        step(0, 0, K_NOP, 12'h000, 2'd0, 2'b11);
        step(1, 0, K_WR, 12'h000, 2'd3, 2'b00);
        check(closed_err_o == 0 && wr_o == 0, "R1 invalid edge ignores", wr_o, 0);
        step(1, 0, K_NOP, 0, 0, 2'b00);
        step(1, 0, K_NOP, 0, 0, 2'b00);
        // R8: bank 2 closed by auto-precharge
        step(1, 0, K_RD, 12'h000, 2'd2, 2'b00);
        check(closed_err_o == 1, "R8 auto-precharge closed bank", closed_err_o, 1);
        // R3: unsupported code
        step(1, 0, K_BAD, 0, 0, 0);
        // R9: write burst with masks
        step(1, 0, K_ACT, 12'h0F0, 2'd0, 2'b00);
        step(1, 0, K_WR, 12'h033, 2'd0, 2'b10);
        check(wr_be_o == 2'b01, "R9 write mask zero latency", wr_be_o, 1);
        step(0, 0, K_NOP, 0, 0, 2'b01);
        // R11: burst prevents power-down
        check(pdown_o == 0, "R11 no pdown in burst", pdown_o, 0);
        step(1, 0, K_NOP, 0, 0, 2'b00);
        step(1, 0, K_NOP, 0, 0, 2'b11);
        step(0, 0, K_NOP, 0, 0, 2'b00);
        step(0, 1, K_NOP, 0, 0, 2'b00);
        check(pdown_o == 1, "R11 enter pdown", pdown_o, 1);
        step(1, 1, K_NOP, 0, 0, 2'b00);
        check(pdown_o == 0, "R11 exit pdown", pdown_o, 0);
        // R6: precharge all
        step(1, 0, K_ACT, 12'h222, 2'd1, 2'b00);
        step(1, 0, K_PRE, 12'h400, 2'd3, 2'b00);
        step(1, 0, K_WR, 12'h000, 2'd0, 2'b00);
        check(closed_err_o == 1, "R6 all banks closed", closed_err_o, 1);
        // R10: read mask latency
        step(1, 0, K_NOP, 0, 0, 2'b10);
        step(1, 0, K_NOP, 0, 0, 2'b01);
        check(rd_mask_o == 2'b10, "R10 two-edge latency", rd_mask_o, 2);

        for (int i = 0; i < 3000; i++) begin
            int r;
            bit [2:0] k;
            r = $urandom_range(0, 99);
            if (r < 25) k = K_ACT; else if (r < 45) k = K_RD; else if (r < 65) k = K_WR;
            else if (r < 78) k = K_PRE; else if (r < 94) k = K_NOP;
            else k = 3'($urandom_range(0, 7));
            step($urandom_range(0, 99) < 88, $urandom_range(0, 99) < 12, k,
                 12'($urandom), 2'($urandom), 2'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule